// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a single-data-rate synchronous DRAM and owns the command bus from reset until the memory is ready for traffic. It drives the chip-select, row-strobe, column-strobe and write-enable lines, the address bus and the bank-select bus. It runs one fixed script: a quiet period of NOP commands while the clock settles, then a precharge of every bank, two auto-refresh commands, and a load of the mode register. When the wait after that load has run out, it raises a done flag so that the normal controller can take over the bus.

The quiet period counts only cycles in which the clock-stable input is high. If that input drops during the quiet period, the count starts again from zero. Every wait between two commands is a parameter in clock cycles. NOP is driven on every cycle of every wait. The mode value comes in on a 12-bit input and is placed on the address bus during the load. The two reserved upper bits are always driven low, whatever the input holds.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low, the command pins show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), addr and ba are zero, and init_done is 0.
- R2: After reset, only NOP appears until clk_stable has been high on T_POWERUP consecutive rising edges. The precharge then appears on the pins on the next edge, so with clk_stable held high it is visible T_POWERUP+1 edges after reset release.
- R3: A cycle with clk_stable low during the quiet period restarts the count. The precharge then appears T_POWERUP+1 edges after the last low edge.
- R4: The precharge is encoded {cs_n,ras_n,cas_n,we_n}=0010, with addr bit 10 high (all banks) and every other addr bit low.
- R5: Exactly two auto-refresh commands (0001) are issued. The first comes T_RP cycles after the precharge and the second T_RFC cycles after the first.
- R6: The mode load (0000) comes T_RFC cycles after the second refresh, with addr[9:0]=mode_word[9:0], addr[11:10]=00 and ba=00.
- R7: init_done rises T_MRD cycles after the mode load and stays high until reset. Every cycle that is not one of the four commands, including every cycle after done, carries NOP.
- R8: After the quiet period ends, clk_stable has no effect on the command timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_stable | input | 1 | High while the memory clock is within its limits |
| mode_word | input | 12 | Mode value for the load; the upper two bits are ignored |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | 12 | Address bus |
| ba | output | 2 | Bank select |
| init_done | output | 1 | High once the sequence is complete |

## Verification
The bench builds the block with T_POWERUP=20, T_RP=3, T_RFC=7 and T_MRD=2. A 20-cycle quiet period lets the bench drop clk_stable in the middle of the count, or hold it low from the start, and still see the restart within a short run. T_MRD=2 is the smallest legal spacing, so the done flag lands right after a NOP. The short refresh and precharge waits let the bench toggle clk_stable on every edge across the whole command phase and check that the spacing does not move.

// File: rtl/sdram_init_pkg.sv
// Package: shared command codes, script phases and a width helper for the
// power-up sequencer. Command codes are {cs_n, ras_n, cas_n, we_n}.
package sdram_init_pkg;

    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdram_cmd_e;

    typedef enum logic [3:0] {
        PH_POWERUP,
        PH_PRECHARGE,
        PH_WAIT_RP,
        PH_REFRESH_A,
        PH_WAIT_RFC_A,
        PH_REFRESH_B,
        PH_WAIT_RFC_B,
        PH_LOAD_MODE,
        PH_WAIT_MRD,
        PH_READY
    } init_phase_e;

    // Larger of two cycle counts, used to size the shared timer.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/init_step_timer.sv
// Module: down-counter shared by every wait of the script.
// Assumes load has priority over dec; expired is high while the count is zero.
module init_step_timer #(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned RESET_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Reload on request, otherwise count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RESET_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/init_cmd_drive.sv
// Module: registers the command, address and done flag onto the pins.
// Assumes the script never issues two commands on back-to-back cycles.
// The bank bus stays at zero, which a precharge of all banks ignores and a
// mode load needs.
module init_cmd_drive
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned BA_W       = 2,
    parameter int unsigned ALL_BANK_B = 10,
    parameter int unsigned MODE_DEF_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sdram_cmd_e        cmd,
    input  logic [ADDR_W-1:0] mode_word,
    input  logic              ready,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              init_done
);
    localparam logic [ADDR_W-1:0] MODE_MASK = (ADDR_W'(1) << MODE_DEF_W) - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << ALL_BANK_B;

    logic [3:0]        cmd_q;
    logic [ADDR_W-1:0] addr_d;
    logic [ADDR_W-1:0] addr_q;
    logic              done_q;

    // Address content for the command about to be issued.
    always_comb begin
        case (cmd)
            CMD_PRE: addr_d = ALL_BANKS;
            CMD_LMR: addr_d = mode_word & MODE_MASK;
            default: addr_d = '0;
        endcase
    end

    // Pin registers; reset leaves the bus in NOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_NOP;
            addr_q <= '0;
            done_q <= 1'b0;
        end else begin
            cmd_q  <= cmd;
            addr_q <= addr_d;
            done_q <= ready;
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
    assign addr      = addr_q;
    assign ba        = '0;
    assign init_done = done_q;

    // R4: a precharge always selects all banks.
    a_r4_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_PRE) |-> (addr_q == ALL_BANKS));
    // R6: the mode load never drives the reserved bits or a bank.
    a_r6_lmr_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_LMR) |-> ((addr_q & ~MODE_MASK) == '0) && (ba == '0));
    // R7: done is sticky until reset.
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> done_q);
    // R7: the bus is quiet once done.
    a_r7_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (cmd_q == CMD_NOP));
    // R7: every issued command is followed by a NOP.
    a_r7_nop_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q != CMD_NOP) |=> (cmd_q == CMD_NOP));

endmodule

// File: rtl/sdram_init_seq.sv
// Module: top of the power-up sequencer. It walks a fixed script: a quiet
// period, a precharge of all banks, two refreshes, a mode load and a final
// wait, then raises init_done.
// Assumes every wait parameter is at least 2 and T_POWERUP is at least 1.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned T_POWERUP = 10000,
    parameter int unsigned T_RP      = 3,
    parameter int unsigned T_RFC     = 7,
    parameter int unsigned T_MRD     = 2,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned BA_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_stable,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              init_done
);
    localparam int unsigned MAX_T = max2(max2(T_POWERUP, T_RP), max2(T_RFC, T_MRD));
    localparam int unsigned CNT_W = (MAX_T < 2) ? 1 : $clog2(MAX_T + 1);
    localparam logic [CNT_W-1:0] LD_PWR = CNT_W'(T_POWERUP - 1);
    localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 2);
    localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(T_RFC - 2);
    localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD - 2);

    init_phase_e      phase_q, phase_d;
    sdram_cmd_e       cmd;
    logic             tmr_load, tmr_dec, tmr_expired;
    logic [CNT_W-1:0] tmr_val;

    // Phase register of the script.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_POWERUP;
        else        phase_q <= phase_d;
    end

    // Next phase, the command of this cycle and the timer control.
    always_comb begin
        phase_d  = phase_q;
        cmd      = CMD_NOP;
        tmr_load = 1'b0;
        tmr_dec  = 1'b0;
        tmr_val  = '0;
        case (phase_q)
            PH_POWERUP: begin
                if (!clk_stable) begin
                    tmr_load = 1'b1;
                    tmr_val  = LD_PWR;
                end else if (tmr_expired) begin
                    phase_d = PH_PRECHARGE;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            PH_PRECHARGE: begin
                cmd = CMD_PRE; tmr_load = 1'b1; tmr_val = LD_RP; phase_d = PH_WAIT_RP;
            end
            PH_WAIT_RP: begin
                if (tmr_expired) phase_d = PH_REFRESH_A; else tmr_dec = 1'b1;
            end
            PH_REFRESH_A: begin
                cmd = CMD_REF; tmr_load = 1'b1; tmr_val = LD_RFC; phase_d = PH_WAIT_RFC_A;
            end
            PH_WAIT_RFC_A: begin
                if (tmr_expired) phase_d = PH_REFRESH_B; else tmr_dec = 1'b1;
            end
            PH_REFRESH_B: begin
                cmd = CMD_REF; tmr_load = 1'b1; tmr_val = LD_RFC; phase_d = PH_WAIT_RFC_B;
            end
            PH_WAIT_RFC_B: begin
                if (tmr_expired) phase_d = PH_LOAD_MODE; else tmr_dec = 1'b1;
            end
            PH_LOAD_MODE: begin
                cmd = CMD_LMR; tmr_load = 1'b1; tmr_val = LD_MRD; phase_d = PH_WAIT_MRD;
            end
            PH_WAIT_MRD: begin
                if (tmr_expired) phase_d = PH_READY; else tmr_dec = 1'b1;
            end
            PH_READY: phase_d = PH_READY;
            default:  phase_d = PH_POWERUP;
        endcase
    end

    init_step_timer #(
        .CNT_W     (CNT_W),
        .RESET_VAL (T_POWERUP - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .expired  (tmr_expired)
    );

    init_cmd_drive #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W)
    ) u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .mode_word (mode_word),
        .ready     (phase_q == PH_READY),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .addr      (addr),
        .ba        (ba),
        .init_done (init_done)
    );

    // R3: an unstable clock keeps the script in the quiet period.
    a_r3_hold_in_powerup: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_POWERUP && !clk_stable) |=> (phase_q == PH_POWERUP));
    // R8: once left, the quiet period is never re-entered.
    a_r8_no_return: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_POWERUP) |=> (phase_q != PH_POWERUP));
    // R2: no command leaves the block before the quiet period ends.
    a_r2_quiet_first: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_POWERUP) |-> (cmd == CMD_NOP));

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
    localparam int TP = 20, TRP = 3, TRFC = 7, TMRD = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_stable = 1'b0;
    logic [11:0] mode_word = '0;
    logic        cs_n, ras_n, cas_n, we_n, init_done;
    logic [11:0] addr;
    logic [1:0]  ba;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    sdram_init_seq #(.T_POWERUP(TP), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable), .mode_word(mode_word),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .ba(ba), .init_done(init_done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // R1: reset state of the pins.
    task automatic t_reset_state();
        rst_n = 1'b0;
        clk_stable = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 cmd", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        check("R1 addr", addr, 0);
        check("R1 ba", ba, 0);
        check("R1 done", init_done, 0);
    endtask

    // Run the full script; clk_stable is low on edges [lo_s, lo_s+lo_n-1];
    // late_tog toggles clk_stable on every edge after the precharge (R8).
    task automatic run_script(input string name, input logic [11:0] mode,
                              input int lo_s, input int lo_n, input bit late_tog);
        int pre_t = 0, ref_a = 0, ref_b = 0, n_ref = 0, lmr_t = 0, done_t = 0;
        int stray = 0, pre_addr = -1, lmr_addr = -1, lmr_ba = -1, drop = 0, busy = 0;
        int exp_pre, exp_done;
        logic [3:0] c;
        exp_pre  = (lo_n > 0) ? (lo_s + lo_n - 1 + TP + 1) : (TP + 1);
        exp_done = exp_pre + TRP + 2 * TRFC + TMRD;
        rst_n = 1'b0;
        mode_word = mode;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int cyc = 1; cyc <= exp_done + 10; cyc++) begin
            if (pre_t != 0 && late_tog) clk_stable = cyc[0];
            else clk_stable = !(lo_n > 0 && cyc >= lo_s && cyc < lo_s + lo_n);
            @(posedge clk);
            @(negedge clk);
            c = {cs_n, ras_n, cas_n, we_n};
            if (done_t != 0 && !init_done) drop++;
            if (init_done && done_t == 0) done_t = cyc;
            if (init_done && c != 4'b0111) busy++;
            case (c)
                4'b0010: if (pre_t == 0) begin pre_t = cyc; pre_addr = addr; end else stray++;
                4'b0001: begin
                    n_ref++;
                    if (n_ref == 1) ref_a = cyc; else if (n_ref == 2) ref_b = cyc;
                end
                4'b0000: if (lmr_t == 0) begin lmr_t = cyc; lmr_addr = addr; lmr_ba = ba; end else stray++;
                4'b0111: ;
                default: stray++;
            endcase
        end
        $display("-- %s", name);
        check("R2/R3 precharge cycle", pre_t, exp_pre);
        check("R4 precharge addr", pre_addr, 12'h400);
        check("R5 refresh count", n_ref, 2);
        check("R5/R8 first refresh spacing", ref_a - pre_t, TRP);
        check("R5/R8 second refresh spacing", ref_b - ref_a, TRFC);
        check("R6/R8 mode load spacing", lmr_t - ref_b, TRFC);
        check("R6 mode load addr", lmr_addr, {2'b00, mode[9:0]});
        check("R6 mode load ba", lmr_ba, 0);
        check("R7 done cycle", done_t - lmr_t, TMRD);
        check("R7 done held", drop, 0);
        check("R7 NOP after done", busy, 0);
        check("R7 stray commands", stray, 0);
    endtask

    initial begin
        t_reset_state();
        run_script("clean start", 12'hC32, 0, 0, 1'b0);
        run_script("glitch mid power-up (R3)", 12'h2A3, 9, 1, 1'b0);
        run_script("stable late from start (R3)", 12'hFFF, 1, 6, 1'b0);
        run_script("stable ignored after quiet period (R8)", 12'h123, 0, 0, 1'b1);
        t_reset_state();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<20000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule